// File: doc/BRIEF.md
# I2C Message-List Sequencer

This block runs a short list of I2C messages on a single bus by issuing byte-level commands to a separate bus master, which handles bit timing. Each message names a 7-bit target address, a direction and a byte count. Write bytes come from one shared input stream and are used in order across all write messages. Read bytes from every read message leave on one output stream in message order.

Before any bus activity, the block checks the request against the two budgets the caller supplies: response capacity and write bytes available. It then opens every message with a START, or a repeated START after the first, and closes the list with exactly one STOP. It stops at the first failing message, still issues a STOP, and reports the cause. At the end it raises a one-cycle done pulse carrying the status, the number of messages finished and the number of bytes read.

The states are IDLE, CHECK, ADDR, DATA, NEXT, STOP and DONE. The transitions are:
- IDLE→CHECK on `start_i`.
- CHECK→DONE on a budget failure or an empty list. CHECK→ADDR otherwise.
- ADDR→DATA when the address is acknowledged and the length is not zero. ADDR→NEXT when it is acknowledged and the length is zero. ADDR→STOP on a NAK or a timeout.
- DATA→DATA for each byte that is not the last. DATA→NEXT after the last byte. DATA→STOP on a NAK of a written byte or on a timeout.
- NEXT→ADDR while messages remain. NEXT→STOP after the final message.
- STOP→DONE when the STOP completes or times out.
- DONE→IDLE.

Top module: `i2c_msg_seq`

## Requirements
- R1: Every message begins with one command of op 0 (START then write byte). Its byte is the 7-bit address in bits 7:1 and the read flag in bit 0. While a command waits for completion and no timeout has occurred, `cmd_valid_o` stays high and the op does not change. Descriptor i sits at `msg_desc_i[i*12 +: 12]` as {address[6:0], read flag, length[3:0]}.
- R2: Op 3 (STOP) is issued once, after the last message. No STOP appears between messages.
- R3: A write message of length L issues L commands of op 1. Each carries `wr_data_i`. `wr_pop_o` pulses once for each acknowledged byte, so the bytes are consumed in order across messages.
- R4: A read message of length L issues L commands of op 2. `cmd_ack_o` is 1 on every byte except the last byte of that message. Each returned byte appears on `rd_data_o` with `rd_valid_o`, in order, and is counted in `rd_count_o`.
- R5: A NAK on an address byte or on a written byte ends the list. A STOP follows, `status_o` = 1, and `msgs_done_o` equals the index of the failing message.
- R6: A command not completed within `timeout_i`+1 cycles of being presented fails with `status_o` = 2. A STOP follows, and `msgs_done_o` equals the index of the failing message.
- R7: If the total read length exceeds `resp_cap_i`, or the total write length exceeds `wr_avail_i`, the block reports `status_o` = 3 with zero messages done and issues no bus command. A total equal to the budget is accepted.
- R8: `done_o` is high for exactly one cycle per request. On success `status_o` = 0 and `msgs_done_o` = `num_msgs_i`.
- R9: A zero-length message issues only its address command. A list of zero messages finishes with status 0 and issues no bus command.
- R10: After reset, `done_o`, `cmd_valid_o`, `wr_pop_o` and `rd_valid_o` are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start_i | input | 1 | Begin executing the list (inputs held stable until done) |
| num_msgs_i | input | IDX_W (3) | Number of messages in the list |
| msg_desc_i | input | MAX_MSGS*12 (48) | Packed message descriptors |
| wr_avail_i | input | TOT_W (7) | Write bytes supplied on the stream |
| resp_cap_i | input | TOT_W (7) | Read byte capacity |
| timeout_i | input | TMO_W (8) | Per-command cycle limit |
| wr_data_i | input | 8 | Head of the write byte stream |
| wr_pop_o | output | 1 | Advance the write stream |
| rd_data_o | output | 8 | Read byte |
| rd_valid_o | output | 1 | Read byte valid |
| cmd_valid_o | output | 1 | Command to bus master valid |
| cmd_op_o | output | 2 | 0 START+write, 1 write, 2 read, 3 STOP |
| cmd_byte_o | output | 8 | Byte to transmit |
| cmd_ack_o | output | 1 | Acknowledge the byte being read |
| bm_done_i | input | 1 | Bus master completed the command |
| bm_nak_i | input | 1 | Transmitted byte was not acknowledged |
| bm_rdata_i | input | 8 | Byte received by the bus master |
| done_o | output | 1 | One-cycle completion pulse |
| status_o | output | 2 | 0 OK, 1 NAK, 2 timeout, 3 parameter error |
| msgs_done_o | output | IDX_W (3) | Messages completed |
| rd_count_o | output | TOT_W (7) | Bytes read |

## Verification
The hardest situation to reach from the ports is a timeout on a command in the middle of a list that must still end with a STOP. The STOP is a separate command, and the same counter that just expired now guards it. The bench bus model can withhold completion for one chosen command index and only for non-STOP ops. The block therefore sits in a read until the limit expires, and the model answers the STOP that follows. The stall hits the first read byte after a completed write message, so the reported count and the empty read stream both show where the list was cut.

// File: rtl/i2c_seq_pkg.sv
package i2c_seq_pkg;
    typedef enum logic [1:0] {
        OP_START_WR = 2'd0,
        OP_WRITE    = 2'd1,
        OP_READ     = 2'd2,
        OP_STOP     = 2'd3
    } bus_op_e;

    typedef enum logic [1:0] {
        ST_OK      = 2'd0,
        ST_NAK     = 2'd1,
        ST_TIMEOUT = 2'd2,
        ST_PARAM   = 2'd3
    } seq_status_e;

    typedef enum logic [2:0] {
        S_IDLE, S_CHECK, S_ADDR, S_DATA, S_NEXT, S_STOP, S_DONE
    } seq_state_e;
endpackage

// File: rtl/i2c_seq_desc_sel.sv
module i2c_seq_desc_sel #(
    parameter int MAX_MSGS = 4,
    parameter int LEN_W    = 4,
    parameter int IDX_W    = 3,
    localparam int DESC_W  = 8 + LEN_W
) (
    input  logic [MAX_MSGS*DESC_W-1:0] desc_i,
    input  logic [IDX_W-1:0]           idx_i,
    output logic [6:0]                 addr_o,
    output logic                       rd_o,
    output logic [LEN_W-1:0]           len_o
);
    logic [DESC_W-1:0] ent [MAX_MSGS];

    for (genvar g = 0; g < MAX_MSGS; g++) begin : g_unpack
        assign ent[g] = desc_i[g*DESC_W +: DESC_W];
    end

    always_comb begin
        addr_o = '0;
        rd_o   = 1'b0;
        len_o  = '0;
        for (int i = 0; i < MAX_MSGS; i++) begin
            if (int'(idx_i) == i) begin
                addr_o = ent[i][DESC_W-1 -: 7];
                rd_o   = ent[i][LEN_W];
                len_o  = ent[i][LEN_W-1:0];
            end
        end
    end
endmodule

// File: rtl/i2c_seq_budget.sv
module i2c_seq_budget #(
    parameter int MAX_MSGS = 4,
    parameter int LEN_W    = 4,
    parameter int IDX_W    = 3,
    parameter int TOT_W    = 7,
    localparam int DESC_W  = 8 + LEN_W
) (
    input  logic [MAX_MSGS*DESC_W-1:0] desc_i,
    input  logic [IDX_W-1:0]           num_i,
    input  logic [TOT_W-1:0]           wr_avail_i,
    input  logic [TOT_W-1:0]           resp_cap_i,
    output logic                       ok_o
);
    logic [TOT_W-1:0] rd_tot, wr_tot;

    always_comb begin
        rd_tot = '0;
        wr_tot = '0;
        for (int i = 0; i < MAX_MSGS; i++) begin
            if (i < int'(num_i)) begin
                if (desc_i[i*DESC_W + LEN_W])
                    rd_tot = rd_tot + TOT_W'(desc_i[i*DESC_W +: LEN_W]);
                else
                    wr_tot = wr_tot + TOT_W'(desc_i[i*DESC_W +: LEN_W]);
            end
        end
        ok_o = (rd_tot <= resp_cap_i) && (wr_tot <= wr_avail_i);
    end
endmodule

// File: rtl/i2c_seq_timer.sv
module i2c_seq_timer #(
    parameter int TMO_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             run_i,
    input  logic             clr_i,
    input  logic [TMO_W-1:0] limit_i,
    output logic             expired_o
);
    logic [TMO_W-1:0] cnt_q;

    assign expired_o = run_i && (cnt_q == limit_i);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)                            cnt_q <= '0;
        else if (!run_i || clr_i || expired_o) cnt_q <= '0;
        else                                   cnt_q <= cnt_q + TMO_W'(1);
    end
endmodule

// File: rtl/i2c_msg_seq.sv
module i2c_msg_seq
    import i2c_seq_pkg::*;
#(
    parameter int MAX_MSGS = 4,
    parameter int LEN_W    = 4,
    parameter int TMO_W    = 8,
    localparam int IDX_W   = $clog2(MAX_MSGS + 1),
    localparam int TOT_W   = LEN_W + IDX_W,
    localparam int DESC_W  = 8 + LEN_W
) (
    input  logic                       clk,
    input  logic                       rst_n,
    input  logic                       start_i,
    input  logic [IDX_W-1:0]           num_msgs_i,
    input  logic [MAX_MSGS*DESC_W-1:0] msg_desc_i,
    input  logic [TOT_W-1:0]           wr_avail_i,
    input  logic [TOT_W-1:0]           resp_cap_i,
    input  logic [TMO_W-1:0]           timeout_i,
    input  logic [7:0]                 wr_data_i,
    output logic                       wr_pop_o,
    output logic [7:0]                 rd_data_o,
    output logic                       rd_valid_o,
    output logic                       cmd_valid_o,
    output logic [1:0]                 cmd_op_o,
    output logic [7:0]                 cmd_byte_o,
    output logic                       cmd_ack_o,
    input  logic                       bm_done_i,
    input  logic                       bm_nak_i,
    input  logic [7:0]                 bm_rdata_i,
    output logic                       done_o,
    output logic [1:0]                 status_o,
    output logic [IDX_W-1:0]           msgs_done_o,
    output logic [TOT_W-1:0]           rd_count_o
);
    seq_state_e        state_q, state_d;
    seq_status_e       stat_q;
    bus_op_e           op;
    logic [IDX_W-1:0]  idx_q;
    logic [LEN_W-1:0]  bcnt_q;
    logic [TOT_W-1:0]  rcnt_q;
    logic [6:0]        cur_addr;
    logic              cur_rd;
    logic [LEN_W-1:0]  cur_len;
    logic              budget_ok, tmo_hit, last_byte, final_msg;

    i2c_seq_desc_sel #(.MAX_MSGS(MAX_MSGS), .LEN_W(LEN_W), .IDX_W(IDX_W)) u_sel (
        .desc_i(msg_desc_i), .idx_i(idx_q),
        .addr_o(cur_addr), .rd_o(cur_rd), .len_o(cur_len)
    );

    i2c_seq_budget #(.MAX_MSGS(MAX_MSGS), .LEN_W(LEN_W), .IDX_W(IDX_W), .TOT_W(TOT_W)) u_budget (
        .desc_i(msg_desc_i), .num_i(num_msgs_i),
        .wr_avail_i(wr_avail_i), .resp_cap_i(resp_cap_i), .ok_o(budget_ok)
    );

    i2c_seq_timer #(.TMO_W(TMO_W)) u_timer (
        .clk(clk), .rst_n(rst_n), .run_i(cmd_valid_o), .clr_i(bm_done_i),
        .limit_i(timeout_i), .expired_o(tmo_hit)
    );

    assign last_byte = (bcnt_q == cur_len - LEN_W'(1));
    assign final_msg = ((idx_q + IDX_W'(1)) == num_msgs_i);

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            S_IDLE:  if (start_i) state_d = S_CHECK;
            S_CHECK: if (!budget_ok || num_msgs_i == '0) state_d = S_DONE;
                     else                                state_d = S_ADDR;
            S_ADDR:  if (bm_done_i)   state_d = bm_nak_i ? S_STOP :
                                                (cur_len == '0) ? S_NEXT : S_DATA;
                     else if (tmo_hit) state_d = S_STOP;
            S_DATA:  if (bm_done_i)   state_d = (!cur_rd && bm_nak_i) ? S_STOP :
                                                last_byte ? S_NEXT : S_DATA;
                     else if (tmo_hit) state_d = S_STOP;
            S_NEXT:  state_d = final_msg ? S_STOP : S_ADDR;
            S_STOP:  if (bm_done_i || tmo_hit) state_d = S_DONE;
            S_DONE:  state_d = S_IDLE;
            default: state_d = S_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= S_IDLE;
        else        state_q <= state_d;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            idx_q  <= '0;
            bcnt_q <= '0;
            rcnt_q <= '0;
            stat_q <= ST_OK;
        end else begin
            unique case (state_q)
                S_IDLE: if (start_i) begin
                    idx_q  <= '0;
                    bcnt_q <= '0;
                    rcnt_q <= '0;
                    stat_q <= ST_OK;
                end
                S_CHECK: if (!budget_ok) stat_q <= ST_PARAM;
                S_ADDR: begin
                    if (bm_done_i) begin
                        bcnt_q <= '0;
                        if (bm_nak_i) stat_q <= ST_NAK;
                    end else if (tmo_hit) stat_q <= ST_TIMEOUT;
                end
                S_DATA: begin
                    if (bm_done_i) begin
                        if (!cur_rd && bm_nak_i) stat_q <= ST_NAK;
                        else                     bcnt_q <= bcnt_q + LEN_W'(1);
                        if (cur_rd)              rcnt_q <= rcnt_q + TOT_W'(1);
                    end else if (tmo_hit) stat_q <= ST_TIMEOUT;
                end
                S_NEXT:  idx_q <= idx_q + IDX_W'(1);
                default: ;
            endcase
        end
    end

    always_comb begin
        cmd_valid_o = 1'b0;
        op          = OP_STOP;
        cmd_byte_o  = 8'h00;
        cmd_ack_o   = 1'b0;
        wr_pop_o    = 1'b0;
        rd_valid_o  = 1'b0;
        unique case (state_q)
            S_ADDR: begin
                cmd_valid_o = 1'b1;
                op          = OP_START_WR;
                cmd_byte_o  = {cur_addr, cur_rd};
            end
            S_DATA: begin
                cmd_valid_o = 1'b1;
                op          = cur_rd ? OP_READ : OP_WRITE;
                cmd_byte_o  = cur_rd ? 8'h00 : wr_data_i;
                cmd_ack_o   = cur_rd && !last_byte;
                wr_pop_o    = !cur_rd && bm_done_i && !bm_nak_i;
                rd_valid_o  = cur_rd && bm_done_i;
            end
            S_STOP:  cmd_valid_o = 1'b1;
            default: ;
        endcase
    end

    assign cmd_op_o    = op;
    assign rd_data_o   = bm_rdata_i;
    assign done_o      = (state_q == S_DONE);
    assign status_o    = stat_q;
    assign msgs_done_o = idx_q;
    assign rd_count_o  = rcnt_q;
endmodule

// File: rtl/i2c_seq_checker.sv
module i2c_seq_checker
    import i2c_seq_pkg::*;
#(
    parameter int IDX_W = 3,
    parameter int TOT_W = 7
) (
    input logic             clk,
    input logic             rst_n,
    input logic             done_o,
    input logic [1:0]       status_o,
    input logic [IDX_W-1:0] msgs_done_o,
    input logic [TOT_W-1:0] rd_count_o,
    input logic [IDX_W-1:0] num_msgs_i,
    input logic             cmd_valid_o,
    input logic [1:0]       cmd_op_o,
    input logic             bm_done_i,
    input logic             wr_pop_o,
    input logic             rd_valid_o,
    input logic             tmo_hit
);
    assert_cmd_hold_R1: assert property (@(posedge clk) disable iff (!rst_n)
        cmd_valid_o && !bm_done_i && !tmo_hit |=> cmd_valid_o && $stable(cmd_op_o));

    assert_wr_pop_R3: assert property (@(posedge clk) disable iff (!rst_n)
        wr_pop_o |-> bm_done_i && cmd_op_o == OP_WRITE);

    assert_rd_valid_R4: assert property (@(posedge clk) disable iff (!rst_n)
        rd_valid_o |-> bm_done_i && cmd_op_o == OP_READ);

    assert_count_bound_R5: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |-> msgs_done_o <= num_msgs_i);

    assert_param_clean_R7: assert property (@(posedge clk) disable iff (!rst_n)
        done_o && status_o == ST_PARAM |-> msgs_done_o == '0 && rd_count_o == '0);

    assert_done_pulse_R8: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |=> !done_o);

    assert_ok_count_R8: assert property (@(posedge clk) disable iff (!rst_n)
        done_o && status_o == ST_OK |-> msgs_done_o == num_msgs_i);
endmodule

bind i2c_msg_seq i2c_seq_checker #(.IDX_W(IDX_W), .TOT_W(TOT_W)) u_seq_chk (
    .clk(clk), .rst_n(rst_n), .done_o(done_o), .status_o(status_o),
    .msgs_done_o(msgs_done_o), .rd_count_o(rd_count_o), .num_msgs_i(num_msgs_i),
    .cmd_valid_o(cmd_valid_o), .cmd_op_o(cmd_op_o), .bm_done_i(bm_done_i),
    .wr_pop_o(wr_pop_o), .rd_valid_o(rd_valid_o), .tmo_hit(tmo_hit)
);

// File: tb/tb_i2c_msg_seq.sv
`timescale 1ns/1ps
module tb_i2c_msg_seq;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        start_i = 1'b0;
    logic [2:0]  num_msgs_i = '0;
    logic [47:0] msg_desc_i = '0;
    logic [6:0]  wr_avail_i = '0;
    logic [6:0]  resp_cap_i = '0;
    logic [7:0]  timeout_i = 8'd10;
    logic [7:0]  wr_data_i;
    logic        wr_pop_o, rd_valid_o, cmd_valid_o, cmd_ack_o, done_o;
    logic [7:0]  rd_data_o, cmd_byte_o;
    logic [1:0]  cmd_op_o, status_o;
    logic        bm_done_i = 1'b0, bm_nak_i = 1'b0;
    logic [7:0]  bm_rdata_i = '0;
    logic [2:0]  msgs_done_o;
    logic [6:0]  rd_count_o;

    i2c_msg_seq dut (.*);

    always #10 clk = ~clk;

    int errors = 0, checks = 0;
    int lat = 1, nak_idx = -1, hang_idx = -1, w = 0;
    int ncmd = 0, nr = 0, wr_ptr = 0, done_cnt = 0;
    logic [1:0] log_op [64];
    logic [7:0] log_byte [64];
    logic       log_ack [64];
    logic [7:0] rbuf [64];
    logic [7:0] wr_mem [16];
    logic [1:0] cap_stat;
    logic [2:0] cap_msgs;
    logic [6:0] cap_rcnt;

    assign wr_data_i = wr_mem[wr_ptr[3:0]];

    task automatic chk(input bit ok, input string tag, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    task automatic chk_eq(input string tag, input int act, input int exp);
        chk(act == exp, tag, act, exp);
    endtask

    // bus master model: acts on falling edges only
    initial begin
        forever begin
            @(negedge clk);
            if (bm_done_i) begin
                bm_done_i = 1'b0;
                bm_nak_i  = 1'b0;
                w = 0;
            end else if (cmd_valid_o && rst_n) begin
                if (ncmd == hang_idx && cmd_op_o != 2'd3) w = 0;
                else if (w >= lat) begin
                    log_op[ncmd]   = cmd_op_o;
                    log_byte[ncmd] = cmd_byte_o;
                    log_ack[ncmd]  = cmd_ack_o;
                    bm_nak_i   = (ncmd == nak_idx);
                    bm_rdata_i = 8'h30 + 8'(ncmd);
                    bm_done_i  = 1'b1;
                    ncmd++;
                end else w++;
            end
        end
    end

    // output monitor: samples 2 ns before each rising edge
    initial begin
        forever begin
            @(negedge clk);
            #8;
            if (rd_valid_o) begin rbuf[nr] = rd_data_o; nr++; end
            if (wr_pop_o) wr_ptr++;
            if (done_o) begin
                done_cnt++;
                cap_stat = status_o;
                cap_msgs = msgs_done_o;
                cap_rcnt = rd_count_o;
            end
        end
    end

    function automatic logic [11:0] mk(input logic [6:0] a, input logic rd, input logic [3:0] len);
        return {a, rd, len};
    endfunction

    task automatic run_seq();
        ncmd = 0; nr = 0; wr_ptr = 0; done_cnt = 0;
        @(negedge clk);
        start_i = 1'b1;
        @(negedge clk);
        start_i = 1'b0;
        for (int i = 0; i < 600 && done_cnt == 0; i++) @(negedge clk);
        repeat (3) @(negedge clk);
        chk_eq("R8 one done pulse", done_cnt, 1);
    endtask

    task automatic cfg_wr_rd();
        num_msgs_i = 3'd2;
        msg_desc_i = '0;
        msg_desc_i[11:0]  = mk(7'h50, 1'b0, 4'd2);
        msg_desc_i[23:12] = mk(7'h50, 1'b1, 4'd2);
        wr_mem[0] = 8'h11; wr_mem[1] = 8'h22;
        wr_avail_i = 7'd2; resp_cap_i = 7'd2;
        lat = 1; nak_idx = -1; hang_idx = -1;
    endtask

    task automatic t_reset();
        #5;
        chk_eq("R10 done low", int'(done_o), 0);
        chk_eq("R10 cmd_valid low", int'(cmd_valid_o), 0);
        chk_eq("R10 pop/rd low", int'(wr_pop_o | rd_valid_o), 0);
    endtask

    task automatic t_write_read();
        cfg_wr_rd();
        run_seq();
        chk_eq("R8 status ok", int'(cap_stat), 0);
        chk_eq("R8 msgs done", int'(cap_msgs), 2);
        chk_eq("R2 cmd count", ncmd, 7);
        chk_eq("R1 addr wr op", int'(log_op[0]), 0);
        chk_eq("R1 addr wr byte", int'(log_byte[0]), 8'hA0);
        chk_eq("R3 byte0", int'(log_byte[1]), 8'h11);
        chk_eq("R3 byte1", int'(log_byte[2]), 8'h22);
        chk_eq("R3 write op", int'(log_op[2]), 1);
        chk_eq("R3 pops", wr_ptr, 2);
        chk_eq("R1 repeated start op", int'(log_op[3]), 0);
        chk_eq("R1 addr rd byte", int'(log_byte[3]), 8'hA1);
        chk_eq("R4 read op", int'(log_op[4]), 2);
        chk_eq("R4 ack first", int'(log_ack[4]), 1);
        chk_eq("R4 nack last", int'(log_ack[5]), 0);
        chk_eq("R2 stop last", int'(log_op[6]), 3);
        chk_eq("R4 rd count", int'(cap_rcnt), 2);
        chk_eq("R4 rdata0", int'(rbuf[0]), 8'h34);
        chk_eq("R4 rdata1", int'(rbuf[1]), 8'h35);
    endtask

    task automatic t_three_msgs();
        num_msgs_i = 3'd3;
        msg_desc_i = '0;
        msg_desc_i[11:0]  = mk(7'h2A, 1'b1, 4'd1);
        msg_desc_i[23:12] = mk(7'h13, 1'b0, 4'd0);
        msg_desc_i[35:24] = mk(7'h7F, 1'b0, 4'd1);
        wr_mem[0] = 8'h9C;
        wr_avail_i = 7'd1; resp_cap_i = 7'd1;
        lat = 3; nak_idx = -1; hang_idx = -1;
        run_seq();
        chk_eq("R7 budget equal accepted", int'(cap_stat), 0);
        chk_eq("R8 msgs done 3", int'(cap_msgs), 3);
        chk_eq("R9 cmd count", ncmd, 6);
        chk_eq("R1 read addr byte", int'(log_byte[0]), 8'h55);
        chk_eq("R4 single byte nack", int'(log_ack[1]), 0);
        chk_eq("R9 zero-len addr", int'(log_byte[2]), 8'h26);
        chk_eq("R9 zero-len then start", int'(log_op[3]), 0);
        chk_eq("R1 addr 7F", int'(log_byte[3]), 8'hFE);
        chk_eq("R3 write data", int'(log_byte[4]), 8'h9C);
        chk_eq("R2 single stop", int'(log_op[5]), 3);
        chk(log_op[1] != 2'd3 && log_op[2] != 2'd3 && log_op[4] != 2'd3,
            "R2 no inner stop", 0, 0);
        chk_eq("R4 rdata", int'(rbuf[0]), 8'h31);
    endtask

    task automatic t_addr_nak();
        cfg_wr_rd();
        nak_idx = 3;
        run_seq();
        chk_eq("R5 status nak", int'(cap_stat), 1);
        chk_eq("R5 msgs done", int'(cap_msgs), 1);
        chk_eq("R5 cmd count", ncmd, 5);
        chk_eq("R5 stop issued", int'(log_op[4]), 3);
        chk_eq("R5 no read data", nr, 0);
    endtask

    task automatic t_data_nak();
        num_msgs_i = 3'd2;
        msg_desc_i = '0;
        msg_desc_i[11:0]  = mk(7'h20, 1'b0, 4'd3);
        msg_desc_i[23:12] = mk(7'h21, 1'b1, 4'd1);
        wr_mem[0] = 8'hC1; wr_mem[1] = 8'hC2; wr_mem[2] = 8'hC3;
        wr_avail_i = 7'd3; resp_cap_i = 7'd1;
        lat = 0; nak_idx = 2; hang_idx = -1;
        run_seq();
        chk_eq("R5 data nak status", int'(cap_stat), 1);
        chk_eq("R5 data nak msgs", int'(cap_msgs), 0);
        chk_eq("R5 data nak cmds", ncmd, 4);
        chk_eq("R5 data nak stop", int'(log_op[3]), 3);
        chk_eq("R3 only acked popped", wr_ptr, 1);
    endtask

    task automatic t_timeout();
        cfg_wr_rd();
        hang_idx = 4;
        run_seq();
        chk_eq("R6 status timeout", int'(cap_stat), 2);
        chk_eq("R6 msgs done", int'(cap_msgs), 1);
        chk_eq("R6 stop after stall", int'(log_op[4]), 3);
        chk_eq("R6 cmd count", ncmd, 5);
        chk_eq("R6 no read data", nr, 0);
    endtask

    task automatic t_param();
        cfg_wr_rd();
        resp_cap_i = 7'd1;
        run_seq();
        chk_eq("R7 read over cap", int'(cap_stat), 3);
        chk_eq("R7 no cmds", ncmd, 0);
        chk_eq("R7 msgs zero", int'(cap_msgs), 0);
        cfg_wr_rd();
        wr_avail_i = 7'd1;
        run_seq();
        chk_eq("R7 write short", int'(cap_stat), 3);
        chk_eq("R7 no cmds write", ncmd, 0);
    endtask

    task automatic t_empty();
        num_msgs_i = 3'd0;
        msg_desc_i = '0;
        wr_avail_i = '0; resp_cap_i = '0;
        run_seq();
        chk_eq("R9 empty status", int'(cap_stat), 0);
        chk_eq("R9 empty no cmds", ncmd, 0);
    endtask

    initial begin
        #(20 * 150000);
        errors++;
        checks++;
        $display("FAIL watchdog expired");
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        for (int i = 0; i < 16; i++) wr_mem[i] = 8'h00;
        t_reset();
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        repeat (2) @(negedge clk);
        t_write_read();
        t_three_msgs();
        t_addr_nak();
        t_data_nak();
        t_timeout();
        t_param();
        t_empty();
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule